// File: doc/BRIEF.md
# Tick-Count Watchdog Timer with Sticky Bark Status

This block is a programmable watchdog. Software loads a 32-bit timeout, expressed as a number of ticks, and the block counts an externally supplied one-cycle tick strobe. If software does not write the timeout register again before the count reaches the loaded value, the watchdog barks. It then raises a board-reset request pulse of fixed length and sets a sticky status flag. If the watchdog output function is enabled at that moment, it also latches a request that forces the watchdog status pin low.

Every write to the timeout register restarts the count from zero, so that write is the kick. A timeout of zero turns the watchdog off. After a bark the counter stays idle until the register is written again. The board-level reset clears the timeout register and the counter. The status flag and the forced-low pin request survive that reset. Only an explicit clear with bit 31 set, or the true power-on reset, removes them. The block does not produce the tick rate and does not distribute the reset.

Top module: `wdog_tick_timer`

## Requirements
- R1: After a write to the timeout register (`to_wr_en` high), `to_rd_data` returns the written value from the next cycle until the next write or board reset.
- R2: While the timeout register holds 0, no tick ever produces a bark or a reset pulse.
- R3: With timeout N > 0 loaded, the bark happens on the clock edge that samples the N-th tick after the last write. From the next cycle `bark_status` reads 1.
- R4: `rst_req` rises in the cycle after the bark edge and stays high for exactly RST_CYCLES clock cycles.
- R5: After a bark, further ticks produce no new bark until the timeout register is written again.
- R6: Any write to the timeout register restarts the tick count from zero. A write in the same cycle as a tick takes precedence over that tick.
- R7: `bark_status` is cleared only by a `stat_clr_wr` pulse with bit 31 of `stat_clr_data` at 1, or by `por_n` low. A clear with bit 31 at 0 has no effect. A bark in the same cycle as a clear wins.
- R8: `board_rst` clears the timeout register (read value 0) and the count, and leaves `bark_status` and `pin_force_low` unchanged.
- R9: `pin_force_low` is set by a bark only while `wdo_func_en` is 1. It is cleared under the same conditions as `bark_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | True power-on reset, asynchronous, active low |
| board_rst | input | 1 | Board-level synchronous reset, active high |
| to_wr_en | input | 1 | Timeout register write strobe (kick) |
| to_wr_data | input | TW | Timeout value in ticks, 0 disables |
| to_rd_data | output | TW | Timeout register readback |
| tick | input | 1 | One-cycle tick strobe |
| stat_clr_wr | input | 1 | Status clear write strobe |
| stat_clr_data | input | 32 | Status clear data, bit 31 clears the bark flag |
| wdo_func_en | input | 1 | Watchdog output pin function enabled |
| rst_req | output | 1 | Board-reset request pulse |
| bark_status | output | 1 | Sticky bark flag |
| pin_force_low | output | 1 | Request to hold the status pin as an output driven low |

## Verification
The hardest situation to reach is the state after a bark that must survive a board reset and then be cleared only by the correct bit. The stimulus first drives the count to its limit with the output function enabled. It then pulses `board_rst` and checks that both sticky outputs hold while the readback returns to zero. Next it writes a clear with bit 31 low, then one with bit 31 high. A second hard point is the kick: timeouts are re-written partway through a count, and a scoreboard of expected pulse start cycles flags any pulse that arrives early, late or uninvited.

// File: rtl/wdog_tick_timer.sv
module wdog_tick_timer #(
  parameter int TW         = 32,
  parameter int RST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          board_rst,
  input  logic          to_wr_en,
  input  logic [TW-1:0] to_wr_data,
  output logic [TW-1:0] to_rd_data,
  input  logic          tick,
  input  logic          stat_clr_wr,
  input  logic [31:0]   stat_clr_data,
  input  logic          wdo_func_en,
  output logic          rst_req,
  output logic          bark_status,
  output logic          pin_force_low
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [TW-1:0] to_q;
  logic [TW-1:0] cnt;
  logic          armed;
  logic [PW-1:0] pulse_cnt;
  logic          bark;
  logic          clr_hit;

  assign bark    = armed && tick && !to_wr_en && !board_rst && (cnt == to_q - TW'(1));
  assign clr_hit = stat_clr_wr && stat_clr_data[31];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      to_q  <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (board_rst) begin
      to_q  <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (to_wr_en) begin
      to_q  <= to_wr_data;
      cnt   <= '0;
      armed <= |to_wr_data;
    end else if (bark) begin
      armed <= 1'b0;
    end else if (armed && tick) begin
      cnt <= cnt + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bark_status   <= 1'b0;
      pin_force_low <= 1'b0;
    end else begin
      if (bark)         bark_status <= 1'b1;
      else if (clr_hit) bark_status <= 1'b0;
      if (bark && wdo_func_en) pin_force_low <= 1'b1;
      else if (clr_hit)        pin_force_low <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              pulse_cnt <= '0;
    else if (bark)           pulse_cnt <= PW'(RST_CYCLES);
    else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - PW'(1);
  end

  assign rst_req    = (pulse_cnt != 0);
  assign to_rd_data = to_q;

  a_r1_readback: assert property (@(posedge clk) disable iff (!por_n)
    (to_wr_en && !board_rst) |=> (to_rd_data == $past(to_wr_data)));
  a_r2_zero_never_barks: assert property (@(posedge clk) disable iff (!por_n)
    (to_q == '0) |-> !bark);
  a_r3_bark_sets_status: assert property (@(posedge clk) disable iff (!por_n)
    bark |=> (bark_status && rst_req));
  a_r5_idle_after_bark: assert property (@(posedge clk) disable iff (!por_n)
    (bark && !to_wr_en) |=> !armed);
  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (bark_status && !clr_hit) |=> bark_status);
  a_r8_pin_survives_board_rst: assert property (@(posedge clk) disable iff (!por_n)
    (board_rst && pin_force_low && !clr_hit) |=> pin_force_low);
  a_r9_pin_needs_func: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_force_low && !(bark && wdo_func_en)) |=> !pin_force_low);
endmodule

// File: tb/wdog_tick_timer_tb.sv
module wdog_tick_timer_tb;
  localparam int TW  = 32;
  localparam int RST = 16;

  logic          clk = 0;
  logic          por_n = 0;
  logic          board_rst = 0;
  logic          to_wr_en = 0;
  logic [TW-1:0] to_wr_data = '0;
  logic [TW-1:0] to_rd_data;
  logic          tick = 0;
  logic          stat_clr_wr = 0;
  logic [31:0]   stat_clr_data = '0;
  logic          wdo_func_en = 0;
  logic          rst_req, bark_status, pin_force_low;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  int expq[$];
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_tick_timer #(.TW(TW), .RST_CYCLES(RST)) u_dut (
    .clk(clk), .por_n(por_n), .board_rst(board_rst), .to_wr_en(to_wr_en),
    .to_wr_data(to_wr_data), .to_rd_data(to_rd_data), .tick(tick),
    .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data),
    .wdo_func_en(wdo_func_en), .rst_req(rst_req), .bark_status(bark_status),
    .pin_force_low(pin_force_low));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected pulse start cycles, measures pulse length
  logic prev_req = 0;
  int   len = 0;
  always @(negedge clk) begin
    if (por_n) begin
      if (rst_req && !prev_req) begin
        pulses++;
        if (expq.size() == 0) check(0, "R3/R5 unexpected reset pulse", cyc, 0);
        else begin
          int e;
          e = expq.pop_front();
          check(cyc == e, "R3 pulse start cycle", cyc, e);
        end
        len = 1;
      end else if (rst_req) len++;
      else if (prev_req) check(len == RST, "R4 pulse length", len, RST);
      prev_req = rst_req;
    end
  end

  task automatic write_to(input logic [TW-1:0] v);
    @(negedge clk); to_wr_en = 1; to_wr_data = v;
    @(negedge clk); to_wr_en = 0;
  endtask

  task automatic ticks(input int n, input bit bark_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      if (bark_last && i == n - 1) expq.push_back(cyc + 1);
      @(negedge clk); tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic clr(input logic [31:0] d);
    @(negedge clk); stat_clr_wr = 1; stat_clr_data = d;
    @(negedge clk); stat_clr_wr = 0;
  endtask

  task automatic brst();
    @(negedge clk); board_rst = 1;
    @(negedge clk); board_rst = 0;
  endtask

  task automatic settle();
    repeat (RST + 4) @(negedge clk);
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    check(rst_req == 0 && bark_status == 0 && pin_force_low == 0, "reset outputs", {rst_req, bark_status, pin_force_low}, 0);
    check(to_rd_data == 0, "R1 reset readback", to_rd_data, 0);

    write_to(32'hDEAD_BEEF);
    check(to_rd_data == 32'hDEAD_BEEF, "R1 readback", to_rd_data, 32'hDEAD_BEEF);

    // R2: zero disables
    write_to(0);
    p0 = pulses;
    ticks(10, 0); settle();
    check(pulses == p0, "R2 zero timeout no pulse", pulses, p0);

    // R3/R4: timeout 5
    write_to(5);
    ticks(4, 0);
    check(bark_status == 0 && pulses == p0, "R3 no bark before Nth tick", bark_status, 0);
    ticks(1, 1);
    check(bark_status == 1, "R3 status set by bark", bark_status, 1);
    check(pin_force_low == 0, "R9 pin not forced when function off", pin_force_low, 0);
    settle();

    // R5: idle after bark
    p0 = pulses;
    ticks(8, 0); settle();
    check(pulses == p0, "R5 idle after bark", pulses, p0);

    // R7: clear behaviour
    clr(32'h7FFF_FFFF);
    check(bark_status == 1, "R7 clear with bit31 low ignored", bark_status, 1);
    clr(32'h8000_0000);
    check(bark_status == 0, "R7 clear with bit31 high", bark_status, 0);

    // R6: kick restarts count
    write_to(3);
    ticks(2, 0);
    write_to(3);
    p0 = pulses;
    ticks(2, 0);
    check(pulses == p0 && bark_status == 0, "R6 kick restarts count", pulses, p0);
    ticks(1, 1); settle();
    check(pulses == p0 + 1, "R6 bark after full count post-kick", pulses, p0 + 1);
    clr(32'h8000_0000);

    // R6: write coinciding with tick wins
    write_to(2);
    ticks(1, 0);
    @(negedge clk); tick = 1; to_wr_en = 1; to_wr_data = 2;
    @(negedge clk); tick = 0; to_wr_en = 0;
    p0 = pulses;
    ticks(1, 0);
    check(pulses == p0, "R6 write beats same-cycle tick", pulses, p0);
    ticks(1, 1); settle();

    // R9/R8: function enabled, then board reset
    clr(32'h8000_0000);
    wdo_func_en = 1;
    write_to(1);
    ticks(1, 1);
    check(pin_force_low == 1, "R9 pin forced on bark", pin_force_low, 1);
    settle();
    wdo_func_en = 0;
    write_to(7);
    brst();
    check(to_rd_data == 0, "R8 board reset clears timeout", to_rd_data, 0);
    check(bark_status == 1, "R8 status survives board reset", bark_status, 1);
    check(pin_force_low == 1, "R8 pin survives board reset", pin_force_low, 1);
    p0 = pulses;
    ticks(9, 0); settle();
    check(pulses == p0, "R8 no bark after board reset", pulses, p0);
    clr(32'h8000_0000);
    check(pin_force_low == 0, "R9 pin cleared by status clear", pin_force_low, 0);

    // R7: power-on reset clears status
    write_to(1); ticks(1, 1); settle();
    check(bark_status == 1, "R3 timeout 1 barks on first tick", bark_status, 1);
    @(negedge clk); por_n = 0;
    @(negedge clk); prev_req = 0; por_n = 1;
    @(negedge clk);
    check(bark_status == 0, "R7 power-on reset clears status", bark_status, 0);

    check(expq.size() == 0, "R3 missing expected pulse", expq.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule